// File: doc/BRIEF.md
# Self-Timed Dual-Rail Adder/Subtractor

This block adds or subtracts two 16-bit operands and reports for itself when the result is settled. It does not wait out a fixed worst-case ripple time. Every carry between bit positions is held as two flags: one meaning "a carry is known" and one meaning "no carry is known". With both flags low, the carry is still unknown.

A bit position whose two operand bits are equal decides its carry-out without looking at its carry-in. Only positions whose operand bits differ must wait for the position below them. Carry knowledge moves up one position per clock cycle, so the time to finish depends on the data. A done flag rises once every carry position holds a known value.

A caller presents the operands and the operation select together with a one-cycle start pulse. It then waits for done and takes the sum and carry-out. For subtraction the second operand is inverted and the carry into bit 0 is forced to a known carry. For addition the carry into bit 0 is a known no-carry.

The sequencer has four states, each with named transitions:
- `ST_IDLE`: after reset. Start moves it to `ST_CLEAR`.
- `ST_CLEAR`: the cycle in which every carry flag reads unknown. It always moves to `ST_EVAL`.
- `ST_EVAL`: carries resolve. It moves to `ST_HOLD` once all positions are known.
- `ST_HOLD`: the result is frozen.

Start in any state returns the sequencer to `ST_CLEAR`.

Top module: `dr_completion_adder`

## Requirements
- R1: With op_sub_i low, {carry_o, sum_o} equals the 17-bit sum opa_i + opb_i once done_o is high.
- R2: With op_sub_i high, {carry_o, sum_o} equals opa_i + (~opb_i) + 1 taken to 17 bits, so carry_o is 1 exactly when opa_i >= opb_i unsigned.
- R3: A bit position whose two effective operand bits are both 0 resolves to no-carry at the first evaluation edge, whatever its carry-in. An all-kill operand pair finishes with latency 1.
- R4: A bit position whose two effective operand bits are both 1 resolves to carry at the first evaluation edge, whatever its carry-in. An all-generate operand pair finishes with latency 1.
- R5: A bit position whose effective operand bits differ stays unknown until its carry-in is known, then copies it one edge later. The longest such run sets the latency.
- R6: No carry position ever shows its carry flag and its no-carry flag high together.
- R7: The edge that samples start_i clears every carry flag to unknown. done_o is low in the following cycle.
- R8: done_o first reads high exactly 1 + L clock edges after the edge that sampled start_i. L is the longest run of consecutive bit positions where opa_i differs from the effective second operand (opb_i, or ~opb_i when subtracting).
- R9: Once done_o is high it stays high, and sum_o and carry_o hold, until the next start_i.
- R10: After reset, done_o, sum_o and carry_o are all 0 until the first start_i.
- R11: A start_i arriving while an operation is still evaluating abandons it. Timing and result then follow the new operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that captures operands and begins an operation |
| op_sub_i | input | 1 | 1 selects subtraction, 0 addition |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| sum_o | output | 16 | Result, valid while done_o is high |
| carry_o | output | 1 | Carry out of the top bit (for subtraction 1 means no borrow) |
| done_o | output | 1 | High when every carry position is resolved |

## Verification
The bench drives operand pairs chosen to stress latency: all positions equal (kill-only and generate-only), a full 16-bit propagate chain, a run placed at the top of the word, and subtraction of equal values, which turns the whole word into a propagate run fed by the injected carry. A design that resolved differing positions early would raise done too soon and give wrong sums on long chains. One that did not clear the flags on start would raise done in the very next cycle with stale data. A start issued during a long evaluation checks that the old chain is dropped rather than merged into the new one. Pseudo-random operands then compare done on every cycle, and sum and carry-out at completion, against an integer reference.

// File: rtl/dr_adder_pkg.sv
package dr_adder_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_EVAL  = 2'd2,
        ST_HOLD  = 2'd3
    } adder_state_e;

    typedef enum logic [1:0] {
        CL_KILL = 2'd0,
        CL_GEN  = 2'd1,
        CL_PROP = 2'd2
    } bit_class_e;

    function automatic bit_class_e classify(input logic x, input logic y);
        if (x != y)
            return CL_PROP;
        else if (x)
            return CL_GEN;
        else
            return CL_KILL;
    endfunction

endpackage

// File: rtl/dr_bit_classify.sv
module dr_bit_classify
    import dr_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]          opa_i,
    input  logic [WIDTH-1:0]          opb_eff_i,
    input  logic                      sub_i,
    output bit_class_e [WIDTH:0]      cls_o
);

    // Position 0 is the injected carry-in: it behaves as a fixed generate or kill
    assign cls_o[0] = sub_i ? CL_GEN : CL_KILL;

    for (genvar g = 0; g < WIDTH; g++) begin : g_cls
        assign cls_o[g+1] = classify(opa_i[g], opb_eff_i[g]);
    end

endmodule

// File: rtl/dr_rail_stage.sv
module dr_rail_stage
    import dr_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 eval_i,
    input  bit_class_e [WIDTH:0] cls_i,
    output logic [WIDTH:0]       cy_o,
    output logic [WIDTH:0]       nc_o
);

    localparam int NPOS = WIDTH + 1;

    for (genvar g = 0; g < NPOS; g++) begin : g_pos
        logic up_cy;
        logic up_nc;
        logic cy_q;
        logic nc_q;

        if (g == 0) begin : g_root
            assign up_cy = 1'b0;
            assign up_nc = 1'b0;
        end else begin : g_link
            assign up_cy = cy_o[g-1];
            assign up_nc = nc_o[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cy_q <= 1'b0;
                nc_q <= 1'b0;
            end else if (clr_i) begin
                cy_q <= 1'b0;
                nc_q <= 1'b0;
            end else if (eval_i) begin
                unique case (cls_i[g])
                    CL_KILL: begin
                        cy_q <= 1'b0;
                        nc_q <= 1'b1;
                    end
                    CL_GEN: begin
                        cy_q <= 1'b1;
                        nc_q <= 1'b0;
                    end
                    CL_PROP: begin
                        cy_q <= up_cy;
                        nc_q <= up_nc;
                    end
                    default: begin
                        cy_q <= 1'b0;
                        nc_q <= 1'b0;
                    end
                endcase
            end
        end

        assign cy_o[g] = cy_q;
        assign nc_o[g] = nc_q;
    end

endmodule

// File: rtl/dr_done_detect.sv
module dr_done_detect #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH:0] cy_i,
    input  logic [WIDTH:0] nc_i,
    output logic           all_done_o
);

    logic [WIDTH:0] known;

    for (genvar g = 0; g <= WIDTH; g++) begin : g_known
        assign known[g] = cy_i[g] | nc_i[g];
    end

    assign all_done_o = &known;

endmodule

// File: rtl/dr_adder_ctrl.sv
module dr_adder_ctrl
    import dr_adder_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         all_done_i,
    output logic         clr_o,
    output logic         eval_o,
    output adder_state_e state_o
);

    adder_state_e state_q;
    adder_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_CLEAR: state_d = ST_EVAL;
                ST_EVAL:  state_d = all_done_i ? ST_HOLD : ST_EVAL;
                ST_HOLD:  state_d = ST_HOLD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        clr_o  = start_i;
        eval_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  eval_o = 1'b0;
            ST_CLEAR: eval_o = 1'b1;
            ST_EVAL:  eval_o = 1'b1;
            ST_HOLD:  eval_o = 1'b0;
            default:  eval_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/dr_completion_adder.sv
module dr_completion_adder
    import dr_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_sub_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             done_o
);

    logic [WIDTH-1:0]     opa_q;
    logic [WIDTH-1:0]     opb_eff_q;
    logic                 sub_q;
    bit_class_e [WIDTH:0] cls;
    logic [WIDTH:0]       cy_rail;
    logic [WIDTH:0]       nc_rail;
    logic                 all_done;
    logic                 clr;
    logic                 eval;
    adder_state_e         state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q     <= '0;
            opb_eff_q <= '0;
            sub_q     <= 1'b0;
        end else if (start_i) begin
            opa_q     <= opa_i;
            opb_eff_q <= op_sub_i ? ~opb_i : opb_i;
            sub_q     <= op_sub_i;
        end
    end

    dr_bit_classify #(.WIDTH(WIDTH)) u_cls (
        .opa_i     (opa_q),
        .opb_eff_i (opb_eff_q),
        .sub_i     (sub_q),
        .cls_o     (cls)
    );

    dr_rail_stage #(.WIDTH(WIDTH)) u_rails (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .eval_i (eval),
        .cls_i  (cls),
        .cy_o   (cy_rail),
        .nc_o   (nc_rail)
    );

    dr_done_detect #(.WIDTH(WIDTH)) u_done (
        .cy_i       (cy_rail),
        .nc_i       (nc_rail),
        .all_done_o (all_done)
    );

    dr_adder_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .all_done_i (all_done),
        .clr_o      (clr),
        .eval_o     (eval),
        .state_o    (state)
    );

    // cy_rail[i] is the carry into bit i; cy_rail[WIDTH] leaves the top bit
    assign sum_o   = opa_q ^ opb_eff_q ^ cy_rail[WIDTH-1:0];
    assign carry_o = cy_rail[WIDTH];
    assign done_o  = all_done;

endmodule

// File: rtl/dr_adder_checker.sv
module dr_adder_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o,
    input logic [WIDTH:0]   cy_rail,
    input logic [WIDTH:0]   nc_rail
);

    AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_rail & nc_rail) == '0); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cy_rail == '0) && (nc_rail == '0) && !done_o); // R7

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o && $stable(sum_o) && $stable(carry_o)); // R9

    AST_RAIL_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (($past(cy_rail) & ~cy_rail) == '0) && (($past(nc_rail) & ~nc_rail) == '0)); // R5

endmodule

bind dr_completion_adder dr_adder_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .done_o  (done_o),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .cy_rail (cy_rail),
    .nc_rail (nc_rail)
);

// File: tb/sim_dr_completion_adder.sv
module sim_dr_completion_adder;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         op_sub_i = 1'b0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic [W-1:0] sum_o;
    logic         carry_o;
    logic         done_o;

    int n_cmp = 0;
    int n_bad = 0;
    int seed  = 32'h1d2c3b4a;

    always #4 clk = ~clk;

    dr_completion_adder #(.WIDTH(W)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_sub_i (op_sub_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .sum_o    (sum_o),
        .carry_o  (carry_o),
        .done_o   (done_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_latency(input logic [W-1:0] a, input logic [W-1:0] be);
        int run = 0;
        int best = 0;
        for (int i = 0; i < W; i++) begin
            if (a[i] != be[i]) begin
                run++;
                if (run > best) best = run;
            end else begin
                run = 0;
            end
        end
        return 1 + best;
    endfunction

    int next_rand_v;
    task automatic next_rand(output logic [W-1:0] v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        v = seed[W-1:0];
    endtask

    // Issue start on the next negedge; returns at the negedge right after the start edge
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        @(negedge clk);
        start_i  = 1'b1;
        opa_i    = a;
        opb_i    = b;
        op_sub_i = s;
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input string tag);
        logic [W-1:0] be;
        logic [W:0]   exp;
        int           lat;
        be  = s ? ~b : b;
        exp = {1'b0, a} + {1'b0, be} + {{W{1'b0}}, s};
        lat = ref_latency(a, be);
        issue(a, b, s);
        for (int j = 0; j <= lat + 2; j++) begin
            if (j == 0)
                chk(done_o == 1'b0, {"R7 done low after start ", tag}, done_o, 0);
            chk(done_o == (j >= lat), {"R8 done timing ", tag}, done_o, (j >= lat));
            if (j >= lat) begin
                chk(sum_o == exp[W-1:0], {s ? "R2 diff " : "R1 sum ", tag}, sum_o, exp[W-1:0]);
                chk(carry_o == exp[W], {s ? "R2 carry " : "R1 carry ", tag}, carry_o, exp[W]);
                if (j > lat)
                    chk(done_o == 1'b1, {"R9 result held ", tag}, done_o, 1);
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: quiet state after reset
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(done_o == 1'b0, "R10 done after reset", done_o, 0);
            chk(sum_o == '0, "R10 sum after reset", sum_o, 0);
            chk(carry_o == 1'b0, "R10 carry after reset", carry_o, 0);
        end

        run_op(16'h0000, 16'h0000, 1'b0, "R3 all kill");
        run_op(16'hFFFF, 16'hFFFF, 1'b0, "R4 all generate");
        run_op(16'hFFFF, 16'h0000, 1'b0, "R5 full propagate chain");
        run_op(16'hFFFF, 16'h0001, 1'b0, "R5 wrap to zero");
        run_op(16'h8000, 16'h7F00, 1'b0, "R5 run at top");
        run_op(16'h1234, 16'h1234, 1'b1, "R2 equal operands");
        run_op(16'h0005, 16'h0009, 1'b1, "R2 borrow");
        run_op(16'h0000, 16'hFFFF, 1'b1, "R2 zero minus max");
        run_op(16'hAAAA, 16'h5555, 1'b0, "R1 alternating");

        // R11: restart in the middle of a long chain
        issue(16'hFFFF, 16'h0000, 1'b0);
        for (int k = 0; k < 4; k++) begin
            chk(done_o == 1'b0, "R11 long op still busy", done_o, 0);
            @(negedge clk);
        end
        run_op(16'h00F0, 16'h000F, 1'b0, "R11 restarted op");

        for (int n = 0; n < 40; n++) begin
            next_rand(ra);
            next_rand(rb);
            run_op(ra, rb, n[0], "R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule